// File: doc/BRIEF.md
# Two-Bus Channelled Transfer Engine

This block copies bytes between a 16-bit-addressed memory bus (bus A) and an 8-bit-addressed peripheral register bus (bus B). It does not carry the data itself. In every transfer cycle it drives one address onto each bus and asserts a read strobe on one bus and a write strobe on the other. The source then places its byte on the shared data lines, and the destination captures it in that same cycle.

Eight channels are present. Each has its own direction, starting bus-A address, fixed bus-B address and byte count. A start pulse latches which channels are enabled. The engine then pulls the processor's ready line low and services the enabled channels one after another, from the lowest number upward. It releases ready once the final byte is done. Addresses, directions and counts are read from the configuration inputs when a channel begins, so they must be held stable while the engine is busy.

Top module: `bridge_dma`

## Requirements
- R1: After reset, `cpu_rdy` is high and all four strobes (`a_rd_n`, `a_wr_n`, `b_rd_n`, `b_wr_n`, active low) are high.
- R2: A `start` pulse sampled while idle pulls `cpu_rdy` low in the next cycle with no strobe asserted. The first byte of the first enabled channel appears in the cycle after that.
- R3: A channel whose `cfg_dir` bit is 0 moves A to B: `a_rd_n` and `b_wr_n` are low, and `a_wr_n` and `b_rd_n` are high, in each of its byte cycles.
- R4: A channel whose `cfg_dir` bit is 1 moves B to A: `a_wr_n` and `b_rd_n` are low, and `a_rd_n` and `b_wr_n` are high, in each of its byte cycles.
- R5: Within a channel, `a_addr` starts at the channel's 16-bit field and rises by one per byte, wrapping from 0xFFFF to 0x0000. `b_addr` holds the channel's 8-bit field for the whole channel.
- R6: A channel with count N produces exactly N byte cycles. A count of 0 produces 65536.
- R7: Enabled channels run in ascending channel order, back to back with no idle cycle between them. Disabled channels are skipped. Channel k's fields are `cfg_a_addr[16k+15:16k]`, `cfg_b_addr[8k+7:8k]`, `cfg_count[16k+15:16k]` and `cfg_dir[k]`.
- R8: In the cycle after the last byte of the last enabled channel, `cpu_rdy` is high and all strobes are high. Strobes are never asserted while `cpu_rdy` is high.
- R9: A `start` pulse that arrives while the engine is busy is ignored. It neither changes the running sequence nor starts a further run.
- R10: A start with no channel enabled holds `cpu_rdy` low for exactly one cycle and asserts no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a run |
| ch_enable | input | 8 | Channel enable mask, latched at start |
| cfg_dir | input | 8 | Per-channel direction, 0 = A to B, 1 = B to A |
| cfg_a_addr | input | 128 | Per-channel starting bus-A address, 16 bits each |
| cfg_b_addr | input | 64 | Per-channel bus-B address, 8 bits each |
| cfg_count | input | 128 | Per-channel byte count, 16 bits each, 0 means 65536 |
| cpu_rdy | output | 1 | Processor ready, low while the engine owns the buses |
| a_addr | output | 16 | Bus-A address |
| b_addr | output | 8 | Bus-B address |
| a_rd_n | output | 1 | Bus-A read strobe, active low |
| a_wr_n | output | 1 | Bus-A write strobe, active low |
| b_rd_n | output | 1 | Bus-B read strobe, active low |
| b_wr_n | output | 1 | Bus-B write strobe, active low |

## Verification
A corrupted remaining-byte count shows up as a channel that ends one cycle early or late. That appears at the ports as the next channel's address, or the release of `cpu_rdy`, shifting by a cycle, and it is caught in the cycle it happens. A wrong pending mask or wrong channel pick shows a bus-B address or strobe pair belonging to the wrong channel in the first byte of that channel. A stuck state register shows as `cpu_rdy` failing to rise, or as strobes appearing during the hold cycle or after release. Every byte cycle is compared in full against a model built from the configuration, so any such fault is reported within a cycle of its first effect.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_MOVE} eng_state_t;

  typedef struct packed {
    logic a_rd_n;
    logic a_wr_n;
    logic b_rd_n;
    logic b_wr_n;
  } strobes_t;

  localparam strobes_t STB_IDLE = 4'b1111;
  localparam strobes_t STB_A2B  = 4'b0110;
  localparam strobes_t STB_B2A  = 4'b1001;
endpackage

// File: rtl/dma_pick.sv
module dma_pick #(
  parameter int NCH = 8,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] pend,
  output logic           valid,
  output logic [IW-1:0]  idx
);
  // lowest set bit wins; scan downward so the last hit is the smallest index
  always_comb begin
    valid = |pend;
    idx   = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (pend[k]) idx = k[IW-1:0];
    end
  end
endmodule

// File: rtl/dma_walker.sv
module dma_walker #(
  parameter int AW = 16,
  parameter int BW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] ld_a,
  input  logic [BW-1:0] ld_b,
  input  logic [CW-1:0] ld_cnt,
  output logic [AW-1:0] a_addr,
  output logic [BW-1:0] b_addr,
  output logic          last
);
  logic [CW:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_addr <= '0;
      b_addr <= '0;
      left   <= '0;
    end else if (load) begin
      a_addr <= ld_a;
      b_addr <= ld_b;
      left   <= (ld_cnt == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, ld_cnt};
    end else if (step) begin
      a_addr <= a_addr + 1'b1;
      left   <= left - 1'b1;
    end
  end

  assign last = (left == {{CW{1'b0}}, 1'b1});

  p_a_step_r5: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (a_addr == $past(a_addr) + 1'b1));

  p_b_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> $stable(b_addr));

  p_no_underrun_r6: assert property (@(posedge clk) disable iff (rst)
    step |-> (left > {{CW{1'b0}}, 1'b1}));
endmodule

// File: rtl/dma_strobe.sv
module dma_strobe
  import dma_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     go,
  input  logic     dir_b2a,
  output strobes_t stb
);
  always_ff @(posedge clk) begin
    if (rst)       stb <= STB_IDLE;
    else if (!go)  stb <= STB_IDLE;
    else           stb <= dir_b2a ? STB_B2A : STB_A2B;
  end

  p_pair_r3: assert property (@(posedge clk) disable iff (rst)
    (stb != STB_IDLE) |-> (stb == STB_A2B || stb == STB_B2A));
endmodule

// File: rtl/bridge_dma.sv
module bridge_dma
  import dma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int BW  = 8,
  parameter int CW  = 16,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NCH-1:0]    ch_enable,
  input  logic [NCH-1:0]    cfg_dir,
  input  logic [NCH*AW-1:0] cfg_a_addr,
  input  logic [NCH*BW-1:0] cfg_b_addr,
  input  logic [NCH*CW-1:0] cfg_count,
  output logic              cpu_rdy,
  output logic [AW-1:0]     a_addr,
  output logic [BW-1:0]     b_addr,
  output logic              a_rd_n,
  output logic              a_wr_n,
  output logic              b_rd_n,
  output logic              b_wr_n
);
  eng_state_t     state;
  logic [NCH-1:0] pend;
  logic [IW-1:0]  cur_ch;
  logic           dir_cur;
  logic           pick_valid;
  logic [IW-1:0]  pick_idx;
  logic           last;
  logic           do_load, do_step, go, dir_next;
  strobes_t       stb;

  dma_pick #(.NCH(NCH)) i_pick (
    .pend  (pend),
    .valid (pick_valid),
    .idx   (pick_idx)
  );

  always_comb begin
    do_load = 1'b0;
    do_step = 1'b0;
    go      = 1'b0;
    case (state)
      ST_HOLD: begin
        do_load = pick_valid;
        go      = pick_valid;
      end
      ST_MOVE: begin
        if (!last) begin
          do_step = 1'b1;
          go      = 1'b1;
        end else begin
          do_load = pick_valid;
          go      = pick_valid;
        end
      end
      default: ;
    endcase
    dir_next = do_load ? cfg_dir[pick_idx] : dir_cur;
  end

  dma_walker #(.AW(AW), .BW(BW), .CW(CW)) i_walk (
    .clk    (clk),
    .rst    (rst),
    .load   (do_load),
    .step   (do_step),
    .ld_a   (cfg_a_addr[int'(pick_idx)*AW +: AW]),
    .ld_b   (cfg_b_addr[int'(pick_idx)*BW +: BW]),
    .ld_cnt (cfg_count[int'(pick_idx)*CW +: CW]),
    .a_addr (a_addr),
    .b_addr (b_addr),
    .last   (last)
  );

  dma_strobe i_stb (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .dir_b2a (dir_next),
    .stb     (stb)
  );

  assign a_rd_n = stb.a_rd_n;
  assign a_wr_n = stb.a_wr_n;
  assign b_rd_n = stb.b_rd_n;
  assign b_wr_n = stb.b_wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pend    <= '0;
      cur_ch  <= '0;
      dir_cur <= 1'b0;
      cpu_rdy <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            pend    <= ch_enable;
            cpu_rdy <= 1'b0;
            state   <= ST_HOLD;
          end
        end
        default: begin
          if (do_load) begin
            pend[pick_idx] <= 1'b0;
            cur_ch         <= pick_idx;
            dir_cur        <= cfg_dir[pick_idx];
            state          <= ST_MOVE;
          end else if (!go) begin
            cpu_rdy <= 1'b1;
            state   <= ST_IDLE;
          end
        end
      endcase
    end
  end

  p_quiet_when_ready_r8: assert property (@(posedge clk) disable iff (rst)
    cpu_rdy |-> (a_rd_n && a_wr_n && b_rd_n && b_wr_n));

  p_hold_first_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_rdy) |-> (a_rd_n && a_wr_n && b_rd_n && b_wr_n));

  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && !go) |=> cpu_rdy);

  p_ascending_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MOVE && do_load) |-> (pick_idx > cur_ch));

  p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MOVE && go) |=> (state == ST_MOVE));
endmodule

// File: tb/test_bridge_dma.sv
module test_bridge_dma;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [7:0]   ch_enable;
  logic [7:0]   cfg_dir;
  logic [127:0] cfg_a_addr;
  logic [63:0]  cfg_b_addr;
  logic [127:0] cfg_count;
  logic         cpu_rdy;
  logic [15:0]  a_addr;
  logic [7:0]   b_addr;
  logic         a_rd_n, a_wr_n, b_rd_n, b_wr_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_dma i_bridge_dma (
    .clk(clk), .rst(rst), .start(start), .ch_enable(ch_enable),
    .cfg_dir(cfg_dir), .cfg_a_addr(cfg_a_addr), .cfg_b_addr(cfg_b_addr),
    .cfg_count(cfg_count), .cpu_rdy(cpu_rdy), .a_addr(a_addr), .b_addr(b_addr),
    .a_rd_n(a_rd_n), .a_wr_n(a_wr_n), .b_rd_n(b_rd_n), .b_wr_n(b_wr_n)
  );

  function automatic logic [4:0] ctl();
    return {cpu_rdy, a_rd_n, a_wr_n, b_rd_n, b_wr_n};
  endfunction

  task automatic chk_ctl(string req, logic [4:0] exp);
    total++;
    if (ctl() !== exp) begin
      bad++;
      $display("FAIL %s rdy/strobes actual=%b expected=%b at %0t", req, ctl(), exp, $time);
    end
  endtask

  task automatic chk_all(string req, logic [28:0] exp);
    logic [28:0] act;
    act = {ctl(), a_addr, b_addr};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s rdy/strobes/a/b actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_ch(int k, logic dir, logic [15:0] a, logic [7:0] b, logic [15:0] cnt);
    cfg_dir[k]            = dir;
    cfg_a_addr[k*16 +: 16] = a;
    cfg_b_addr[k*8 +: 8]   = b;
    cfg_count[k*16 +: 16]  = cnt;
  endtask

  // Pulses start with the given mask and checks every cycle until release.
  // poke >= 0 raises start (with all channels enabled) in that byte cycle.
  task automatic run_check(logic [7:0] mask, string tag, int poke);
    int n = 0;
    @(negedge clk);
    ch_enable = mask;
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
    chk_ctl("R2", 5'b01111);
    for (int k = 0; k < 8; k++) begin
      if (mask[k]) begin
        int cnt;
        logic [4:0] pat;
        cnt = (cfg_count[k*16 +: 16] == 16'd0) ? 65536 : int'(cfg_count[k*16 +: 16]);
        pat = cfg_dir[k] ? 5'b01001 : 5'b00110;
        for (int i = 0; i < cnt; i++) begin
          logic [15:0] ea;
          @(negedge clk);
          if (n == poke) begin
            start     = 1'b1;
            ch_enable = 8'hFF;
          end else begin
            start = 1'b0;
          end
          ea = cfg_a_addr[k*16 +: 16] + 16'(i);
          chk_all(tag, {pat, ea, cfg_b_addr[k*8 +: 8]});
          n++;
        end
      end
    end
    @(negedge clk);
    start = 1'b0;
    chk_ctl("R8", 5'b11111);
  endtask

  task automatic t_reset();
    chk_ctl("R1", 5'b11111);
  endtask

  task automatic t_a_to_b();
    set_ch(2, 1'b0, 16'h1200, 8'h18, 16'd3);
    run_check(8'b0000_0100, "R3", -1);
  endtask

  task automatic t_b_to_a();
    set_ch(5, 1'b1, 16'h7F00, 8'h39, 16'd4);
    run_check(8'b0010_0000, "R4", -1);
  endtask

  task automatic t_wrap();
    set_ch(4, 1'b0, 16'hFFFE, 8'h04, 16'd4);
    run_check(8'b0001_0000, "R5", -1);
  endtask

  task automatic t_order();
    set_ch(1, 1'b1, 16'h0100, 8'h11, 16'd2);
    set_ch(3, 1'b0, 16'h0300, 8'h33, 16'd1);
    set_ch(6, 1'b1, 16'h0600, 8'h66, 16'd3);
    run_check(8'b0100_1010, "R7", -1);
  endtask

  task automatic t_busy_start();
    set_ch(0, 1'b0, 16'hA000, 8'h80, 16'd5);
    set_ch(7, 1'b1, 16'hB000, 8'h81, 16'd2);
    run_check(8'b1000_0001, "R9", 2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_ctl("R9", 5'b11111);
    end
  endtask

  task automatic t_empty();
    run_check(8'b0000_0000, "R10", -1);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk_ctl("R10", 5'b11111);
    end
  endtask

  task automatic t_full_count();
    set_ch(0, 1'b1, 16'h0040, 8'h22, 16'd0);
    run_check(8'b0000_0001, "R6", -1);
  endtask

  initial begin
    rst        = 1'b1;
    start      = 1'b0;
    ch_enable  = '0;
    cfg_dir    = '0;
    cfg_a_addr = '0;
    cfg_b_addr = '0;
    cfg_count  = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_a_to_b();
    t_b_to_a();
    t_wrap();
    t_order();
    t_busy_start();
    t_empty();
    t_full_count();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule